// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the bus side of a byte-wide nonvolatile memory that answers on a two-wire I2C bus. SCL and SDA are oversampled by the system clock. The block finds START and STOP conditions and matches the incoming device address against two strap pins. It then takes a two-byte word address and either loads data bytes into a 64-byte page buffer or streams bytes out of the array. The array is modelled by a synchronous RAM of `2**MEM_AW` bytes. The word address on the bus is always 15 bits wide (32 768 words). Address bits at and above `MEM_AW` alias, so the default configuration stays small.

A write sequence is committed only at the STOP that ends it. The commit starts a self-timed write window of `WR_CYCLES` clocks, or 64 clocks if that value is smaller. During this window the buffered bytes are copied into the array and the block ignores its own address. A write-protect pin sampled at STOP suppresses the commit entirely. After reset the block refuses all traffic for `STARTUP_CYCLES` clocks.

The bus state machine has these states:

- `ST_IDLE`: waiting for a START.
- `ST_DEV` and `ST_DEV_ACK`: device address and its acknowledge.
- `ST_AHI`, `ST_AHI_ACK`, `ST_ALO` and `ST_ALO_ACK`: word address, high byte then low byte.
- `ST_WDATA` and `ST_WDATA_ACK`: data bytes being loaded.
- `ST_RDATA` and `ST_RD_ACK`: a byte shifted out, then the master's acknowledge.
- `ST_IGNORE`: silent until the next START or STOP.

The transitions are:

- A START enters `ST_DEV` from any state.
- A STOP returns to `ST_IDLE` from any state.
- After 8 bits, `ST_DEV` goes to `ST_DEV_ACK` on an address hit and to `ST_IGNORE` otherwise.
- `ST_DEV_ACK` goes to `ST_RDATA` for a read and to `ST_AHI` for a write.
- Each receive state goes to its acknowledge state after 8 bits.
- `ST_AHI_ACK` goes to `ST_ALO`, `ST_ALO_ACK` goes to `ST_WDATA`, and `ST_WDATA_ACK` goes back to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RD_ACK` after 8 bits.
- `ST_RD_ACK` goes back to `ST_RDATA` when the master acknowledges, and to `ST_IGNORE` when it does not.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: During and after reset, SDA is released (`sda_low_o` = 0) and the bus state machine is idle.
- R2: For `STARTUP_CYCLES` clocks after reset, no device address is acknowledged.
- R3: A device address byte is acknowledged only if it reads `1010 x A1 A0 rw` (MSB first), with A1/A0 equal to `strap_i[1]`/`strap_i[0]`. Bit 3 (`x`) is don't-care. Any other byte gets no acknowledge.
- R4: The word address is sent high byte first. Bit 7 of the high byte is ignored. Array location = word address modulo `2**MEM_AW`.
- R5: Bytes written are loaded into the page buffer and reach the array only after the STOP ending the sequence. They are readable once the write window ends.
- R6: During a multi-byte write, address bits [5:0] increment and wrap inside the 64-byte page while bits [14:6] stay fixed. Locations outside the page are untouched.
- R7: For the whole write window after a commit, SDA stays released and the device address is not acknowledged.
- R8: If `wp_i` is high at the STOP, data bytes are still acknowledged. No write window starts (the next address is acknowledged at once), and the array is unchanged.
- R9: A random read (address write, repeated START, read header) returns the byte at the given word address.
- R10: A current-address read returns the byte at the internal pointer. After a write, the pointer is the location after the last byte loaded (page-wrapped). During a read, it advances only on a master ACK.
- R11: A sequential read returns consecutive bytes while the master acknowledges, rolling over from word address 0x7FFF to 0x0000. A NACK then STOP ends it.
- R12: A START at any point restarts address reception and discards pending data, and a STOP returns to idle. A STOP not preceded by data bytes since the last START starts no write window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_low_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| strap_i | input | 2 | Address straps: [1] = A1, [0] = A0 |
| wp_i | input | 1 | Write protect, 1 = array may not be programmed |

## Verification
The embedded assertions watch the following on every clock:

- SDA stays released throughout the write window and the startup lockout.
- A write window can begin only on the clock after a detected STOP.
- A STOP always lands the machine in idle.
- The window lasts exactly its programmed length.

The data path can only be shown by the bench's bus scenarios, namely:

- strap and don't-care address matching;
- the deferral of array updates to STOP;
- page wrap;
- the write-protect path;
- pointer behaviour in current, random and sequential reads;
- the rollover at the top of the address space.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int PAGE_BYTES = 64;
    localparam int PAGE_AW    = $clog2(PAGE_BYTES);
    localparam int WORD_AW    = 15;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_e;

endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_o
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], raw[g]};
            end
        end
        assign synced[g] = chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '1;
        end else begin
            prev <= synced;
        end
    end

    // index 1 = SCL, index 0 = SDA
    assign scl_rise_o = synced[1] & ~prev[1];
    assign scl_fall_o = ~synced[1] & prev[1];
    assign start_o    = synced[1] & prev[1] & prev[0] & ~synced[0];
    assign stop_o     = synced[1] & prev[1] & ~prev[0] & synced[0];
    assign sda_o      = synced[0];

endmodule

// File: rtl/eep_timer.sv
module eep_timer #(
    parameter int STARTUP_CYCLES = 125000,
    parameter int WR_CYCLES      = 1250000,
    parameter int PAGE_BYTES     = 64,
    parameter int PAGE_AW        = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_go_i,
    output logic               lockout_o,
    output logic               busy_o,
    output logic               commit_en_o,
    output logic [PAGE_AW-1:0] commit_idx_o
);

    localparam int WR_LEN = (WR_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WR_CYCLES;
    localparam int CW     = $clog2(WR_LEN);
    localparam int LW     = $clog2(STARTUP_CYCLES + 2);
    localparam logic [CW-1:0] WR_LAST  = CW'(WR_LEN - 1);
    localparam logic [CW-1:0] PG_LIMIT = CW'(PAGE_BYTES);
    localparam logic [LW-1:0] SU_END   = LW'(STARTUP_CYCLES);

    logic [LW-1:0] su_cnt;
    logic [CW-1:0] wr_cnt;
    logic          busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            su_cnt <= '0;
        end else if (su_cnt != SU_END) begin
            su_cnt <= su_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wr_cnt <= '0;
        end else if (!busy_q) begin
            if (commit_go_i) begin
                busy_q <= 1'b1;
                wr_cnt <= '0;
            end
        end else if (wr_cnt == WR_LAST) begin
            busy_q <= 1'b0;
        end else begin
            wr_cnt <= wr_cnt + 1'b1;
        end
    end

    assign lockout_o    = (su_cnt != SU_END);
    assign busy_o       = busy_q;
    assign commit_en_o  = busy_q && (wr_cnt < PG_LIMIT);
    assign commit_idx_o = wr_cnt[PAGE_AW-1:0];

    // R7
    wr_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(wr_cnt) == WR_LAST));

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int DW         = 8,
    parameter int PAGE_BYTES = 64,
    parameter int PAGE_AW    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               wr_en_i,
    input  logic [PAGE_AW-1:0] wr_idx_i,
    input  logic [DW-1:0]      wr_data_i,
    input  logic [PAGE_AW-1:0] rd_idx_i,
    output logic [DW-1:0]      rd_data_o,
    output logic               rd_valid_o
);

    logic [DW-1:0]         ent [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld;

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            ent[wr_idx_i] <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (clr_i) begin
            vld <= '0;
        end else if (wr_en_i) begin
            vld[wr_idx_i] <= 1'b1;
        end
    end

    assign rd_data_o  = ent[rd_idx_i];
    assign rd_valid_o = vld[rd_idx_i];

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        rdata_o <= mem[raddr_i];
    end

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import eep_pkg::*;
#(
    parameter int MEM_AW         = 11,
    parameter int STARTUP_CYCLES = 125000,
    parameter int WR_CYCLES      = 1250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_low_o,
    input  logic [1:0] strap_i,
    input  logic       wp_i
);

    localparam int BASE_W = WORD_AW - PAGE_AW;

    // bus conditions
    logic scl_rise, scl_fall, start_det, stop_det, sda_s;

    eep_bus_cond #(.SYNC_STAGES(2)) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .sda_o      (sda_s)
    );

    logic [1:0] wp_sync;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_sync <= 2'b11;
        end else begin
            wp_sync <= {wp_sync[0], wp_i};
        end
    end

    // state and datapath registers
    bus_state_e             state, state_d;
    logic [3:0]             bitcnt;
    logic [7:0]             shreg;
    logic [7:0]             tx_sh;
    logic                   rw_q;
    logic                   mack_q;
    logic                   wr_seen;
    logic [6:0]             hi_q;
    logic [WORD_AW-1:0]     addr_ptr;
    logic [BASE_W-1:0]      page_base;

    // timing and commit
    logic               lockout, busy, commit_en, commit_go;
    logic [PAGE_AW-1:0] commit_idx;

    assign commit_go = stop_det && wr_seen && !wp_sync[1] && !busy;

    eep_timer #(
        .STARTUP_CYCLES (STARTUP_CYCLES),
        .WR_CYCLES      (WR_CYCLES),
        .PAGE_BYTES     (PAGE_BYTES),
        .PAGE_AW        (PAGE_AW)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_go_i  (commit_go),
        .lockout_o    (lockout),
        .busy_o       (busy),
        .commit_en_o  (commit_en),
        .commit_idx_o (commit_idx)
    );

    // strobes
    logic byte_end, dev_hit, alo_done, wdata_done;

    assign byte_end   = scl_fall && (bitcnt == 4'd8);
    assign dev_hit    = (shreg[7:4] == DEV_TYPE) && (shreg[2:1] == strap_i)
                        && !busy && !lockout;
    assign alo_done   = (state == ST_ALO) && byte_end;
    assign wdata_done = (state == ST_WDATA) && byte_end;

    // page buffer
    logic [7:0] pb_data;
    logic       pb_valid;

    eep_page_buf #(
        .DW         (8),
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_AW    (PAGE_AW)
    ) u_pbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (alo_done),
        .wr_en_i    (wdata_done),
        .wr_idx_i   (addr_ptr[PAGE_AW-1:0]),
        .wr_data_i  (shreg),
        .rd_idx_i   (commit_idx),
        .rd_data_o  (pb_data),
        .rd_valid_o (pb_valid)
    );

    // array
    logic [WORD_AW-1:0] commit_addr;
    logic [7:0]         rd_q;
    logic               mem_we;

    assign commit_addr = {page_base, commit_idx};
    assign mem_we      = commit_en && pb_valid;

    eep_array #(.AW(MEM_AW), .DW(8)) u_array (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (commit_addr[MEM_AW-1:0]),
        .wdata_i (pb_data),
        .raddr_i (addr_ptr[MEM_AW-1:0]),
        .rdata_o (rd_q)
    );

    // next state
    always_comb begin
        state_d = state;
        if (start_det) begin
            state_d = ST_DEV;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_d = ST_IDLE;
                ST_DEV:       if (byte_end) state_d = dev_hit ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:   if (scl_fall) state_d = rw_q ? ST_RDATA : ST_AHI;
                ST_AHI:       if (byte_end) state_d = ST_AHI_ACK;
                ST_AHI_ACK:   if (scl_fall) state_d = ST_ALO;
                ST_ALO:       if (byte_end) state_d = ST_ALO_ACK;
                ST_ALO_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (byte_end) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && bitcnt == 4'd7) state_d = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall) state_d = mack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_d = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= '0;
            tx_sh    <= '1;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            wr_seen  <= 1'b0;
            hi_q     <= '0;
            addr_ptr <= '0;
        end else if (start_det || stop_det) begin
            bitcnt  <= '0;
            wr_seen <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_AHI, ST_ALO, ST_WDATA: begin
                    if (scl_rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (byte_end) begin
                        bitcnt <= '0;
                        if (state == ST_DEV)   rw_q <= shreg[0];
                        if (state == ST_AHI)   hi_q <= shreg[6:0];
                        if (state == ST_ALO)   addr_ptr <= {hi_q, shreg};
                        if (state == ST_WDATA) begin
                            addr_ptr[PAGE_AW-1:0] <= addr_ptr[PAGE_AW-1:0] + 1'b1;
                            wr_seen <= 1'b1;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall && rw_q) tx_sh <= rd_q;
                end
                ST_RDATA: begin
                    if (scl_fall && bitcnt != 4'd7) begin
                        tx_sh  <= {tx_sh[6:0], 1'b1};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_s;
                        if (!sda_s) addr_ptr <= addr_ptr + 1'b1;
                    end
                    if (scl_fall) begin
                        tx_sh  <= rd_q;
                        bitcnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_base <= '0;
        end else if (commit_go) begin
            page_base <= addr_ptr[WORD_AW-1:PAGE_AW];
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDATA_ACK: sda_low_o = 1'b1;
            ST_RDATA: sda_low_o = ~tx_sh[7];
            default:  sda_low_o = 1'b0;
        endcase
    end

    // R7
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_low_o);

    // R2
    lockout_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> !sda_low_o);

    // R5
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R12
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R12
    start_to_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV));

endmodule

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;

    localparam int H = 10;
    localparam logic [1:0] STRAP = 2'b10;
    localparam logic [7:0] DEV_W = {4'b1010, 1'b0, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, 1'b0, STRAP, 1'b1};
    localparam int WAIT_WR = 420;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_low;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_low;

    i2c_eeprom_slave #(
        .MEM_AW         (11),
        .STARTUP_CYCLES (400),
        .WR_CYCLES      (300)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_low_o (sda_low),
        .strap_i   (STRAP),
        .wp_i      (wp)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wclk(H);
        scl = 1'b1;   wclk(H);
        sda_m = 1'b0; wclk(H);
        scl = 1'b0;   wclk(H);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wclk(H);
        scl = 1'b1;   wclk(H);
        sda_m = 1'b1; wclk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wclk(H);
            scl = 1'b1;   wclk(H);
            scl = 1'b0;
        end
        sda_m = 1'b1; wclk(H);
        scl = 1'b1;   wclk(H / 2);
        ack = ~sda_line;
        wclk(H / 2);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wclk(H);
            scl = 1'b1;   wclk(H / 2);
            b[i] = sda_line;
            wclk(H / 2);
            scl = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wclk(H);
        scl = 1'b1; wclk(H);
        scl = 1'b0;
    endtask

    // header + word address, returns 1 if all three bytes acked
    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, output logic ok);
        logic a0, a1, a2;
        bus_start;
        send_byte(DEV_W, a0);
        send_byte(hi, a1);
        send_byte(lo, a2);
        ok = a0 & a1 & a2;
    endtask

    task automatic write_mem(input logic [14:0] addr, input logic [7:0] d, input string req);
        logic ok, ad;
        set_addr({1'b0, addr[14:8]}, addr[7:0], ok);
        send_byte(d, ad);
        bus_stop;
        chk(req, "write acks", {31'd0, ok & ad}, 32'd1);
        wclk(WAIT_WR);
    endtask

    task automatic read_seq(input logic [14:0] addr, input int n, input logic [7:0] first,
                            input int step_wrap, input string req);
        logic ok, ar;
        logic [7:0] b;
        set_addr({1'b0, addr[14:8]}, addr[7:0], ok);
        bus_start;
        send_byte(DEV_R, ar);
        chk(req, "read header acks", {31'd0, ok & ar}, 32'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(req, $sformatf("seq byte %0d", i), {24'd0, b},
                {24'd0, 8'(first + 8'(i * step_wrap))});
        end
        bus_stop;
    endtask

    initial begin
        logic ack, ok;
        logic [7:0] b;

        wclk(5);
        // R1: reset state
        chk("R1", "sda released in reset", {31'd0, sda_low}, 32'd0);
        rst_n = 1'b1;
        wclk(2);
        chk("R1", "sda released after reset", {31'd0, sda_low}, 32'd0);

        // R2: lockout right after reset
        bus_start;
        send_byte(DEV_W, ack);
        bus_stop;
        chk("R2", "no ack during startup lockout", {31'd0, ack}, 32'd0);
        wclk(400);

        // R3: exhaustive strap and don't-care sweep
        for (int s = 0; s < 4; s++) begin
            for (int dc = 0; dc < 2; dc++) begin
                bus_start;
                send_byte({4'b1010, 1'(dc), 2'(s), 1'b0}, ack);
                bus_stop;
                chk("R3", $sformatf("strap %0d dc %0d", s, dc), {31'd0, ack},
                    {31'd0, (2'(s) == STRAP)});
            end
        end
        bus_start;
        send_byte({4'b1011, 1'b0, STRAP, 1'b0}, ack);
        bus_stop;
        chk("R3", "wrong device type", {31'd0, ack}, 32'd0);

        // R4 + R5: byte write with high address bit 7 set
        set_addr(8'h81, 8'h23, ok);
        send_byte(8'h3C, ack);
        bus_stop;
        chk("R5", "byte write acks", {31'd0, ok & ack}, 32'd1);
        // R7: busy window ignores address
        bus_start;
        send_byte(DEV_W, ack);
        bus_stop;
        chk("R7", "no ack during write window", {31'd0, ack}, 32'd0);
        wclk(WAIT_WR);
        // R9 random read, R4 alias of top bit
        read_seq(15'h0123, 1, 8'h3C, 0, "R9");

        // R10: current address after NACKed read stays
        bus_start;
        send_byte(DEV_R, ack);
        recv_byte(1'b0, b);
        bus_stop;
        chk("R10", "current read after nacked read", {23'd0, ack, b}, {23'd0, 1'b1, 8'h3C});

        // R10: pointer after write
        write_mem(15'h0201, 8'h22, "R10");
        write_mem(15'h0200, 8'h11, "R10");
        bus_start;
        send_byte(DEV_R, ack);
        recv_byte(1'b0, b);
        bus_stop;
        chk("R10", "current read after write", {23'd0, ack, b}, {23'd0, 1'b1, 8'h22});

        // R6: page write with wrap
        write_mem(15'h0444, 8'h99, "R6");
        write_mem(15'h0480, 8'h77, "R6");
        set_addr(8'h04, 8'h7C, ok);
        for (int i = 0; i < 8; i++) begin
            send_byte(8'(8'h30 + i), ack);
            ok = ok & ack;
        end
        bus_stop;
        chk("R6", "page write acks", {31'd0, ok}, 32'd1);
        wclk(WAIT_WR);
        read_seq(15'h047C, 4, 8'h30, 1, "R6");
        read_seq(15'h0440, 4, 8'h34, 1, "R6");
        read_seq(15'h0444, 1, 8'h99, 0, "R6");
        read_seq(15'h0480, 1, 8'h77, 0, "R6");

        // R8: write protect
        write_mem(15'h0300, 8'h55, "R8");
        wp = 1'b1;
        wclk(4);
        set_addr(8'h03, 8'h00, ok);
        send_byte(8'hAA, ack);
        bus_stop;
        chk("R8", "data acked under protect", {31'd0, ok & ack}, 32'd1);
        bus_start;
        send_byte(DEV_W, ack);
        bus_stop;
        chk("R8", "no write window under protect", {31'd0, ack}, 32'd1);
        wp = 1'b0;
        read_seq(15'h0300, 1, 8'h55, 0, "R8");

        // R11: rollover at top of address space
        write_mem(15'h7FFF, 8'hA5, "R11");
        write_mem(15'h0000, 8'h5A, "R11");
        read_seq(15'h7FFF, 2, 8'hA5, 8'hB5, "R11");

        // R12: START aborts pending data
        write_mem(15'h0500, 8'h12, "R12");
        set_addr(8'h05, 8'h00, ok);
        send_byte(8'hEE, ack);
        set_addr(8'h05, 8'h00, ok);
        bus_stop;
        bus_start;
        send_byte(DEV_W, ack);
        bus_stop;
        chk("R12", "no write window after aborted data", {31'd0, ack}, 32'd1);
        read_seq(15'h0500, 1, 8'h12, 0, "R12");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule